// File: doc/BRIEF.md
# Two-Wire Serial Control Register Slave

This block is a slave on a two-wire serial control bus. It holds a bank of 128 eight-bit control registers that a host microcontroller can write and read. The host drives a serial clock line and a serial data line into the block. The block answers on a third, separate output line. On that line it drives a high acknowledge, and during reads it drives the register bits inverted. All register contents leave the block on a flat parallel bus, so the rest of the chip can use the settings directly.

A transfer opens with a start condition and a device address byte. For a write, the next byte loads an internal register pointer. Every byte after that is stored at the pointer, and the pointer then advances by one. To read, the host sets the pointer with a write transfer, issues a stop and a new start, and sends the read device address. The block then streams bytes from the pointer for as long as the host acknowledges each one. Both serial inputs are sampled into the system clock domain through synchronizer flops, and every bus event is decoded there.

Top module: `serial_regbank_slave`

## Requirements
- R1: After reset (active-low `rst_n`), every register reads 0x00 on `reg_bus_o` and `resp_o` is low.
- R2: With the serial clock high, a high-to-low change of the data line is a start and a low-to-high change is a stop. A stop returns the block to idle, drives `resp_o` low and leaves the registers untouched.
- R3: Bytes travel MSB first over 9 serial clocks. On the 9th clock the block drives `resp_o` high when it accepts the byte. A device address of 0x24 (write) or 0x25 (read) is accepted.
- R4: In a write transfer, the byte after the device address sets the 7-bit register pointer (bit 7 is ignored). Each following byte is stored at the pointer, and the pointer then increases by one. The register at pointer p appears on `reg_bus_o[8p+7:8p]`.
- R5: The pointer wraps from 0x7F to 0x00, for both writes and reads.
- R6: After the read device address, the register at the pointer is shifted out MSB first on `resp_o`, inverted (a stored 1 is driven low). `resp_o` changes only after a falling serial clock edge.
- R7: If the host pulls the data line low on the 9th clock of a read byte (acknowledge), the next register is sent, with the pointer advanced by one.
- R8: If the host leaves the data line high on the 9th clock of a read byte, the block holds `resp_o` low until the next start, whatever the serial clock does.
- R9: A device address other than 0x24 or 0x25 gets no acknowledge. The block then ignores the rest of the transfer, and no register changes, until the next start.
- R10: A start in the middle of a transfer, with no stop before it, begins a new device address byte. The pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk_i | input | 1 | Serial clock line from the host |
| ser_dat_i | input | 1 | Serial data line from the host |
| resp_o | output | 1 | Acknowledge and inverted read data to the host |
| reg_bus_o | output | 1024 | All 128 registers, register p at bits 8p+7 to 8p |

## Verification
The checker watches several rules on every cycle. It checks that `resp_o` is low in idle and after every stop. It checks that `resp_o` stays silent after an address mismatch or a host not-acknowledge. It checks that `resp_o` rises only after a falling serial clock edge, that every register write advances the pointer by exactly one with wrap, and that no write happens during a read transfer. The bench scenarios cover what the checker cannot see. These are the stored values on the parallel bus, the inverted MSB-first read bytes, the acknowledge levels seen by the host, burst wrap across 0x7F, and the repeated-start path.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } sr_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_PTR,
    K_DATA
  } sr_kind_e;
endpackage

// File: rtl/sr_line_sync.sv
module sr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ch, sda_ch;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  // Idle bus is high on both lines, so reset to ones to avoid false events.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ch <= '1;
      sda_ch <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ch <= {scl_ch[STAGES-2:0], scl_i};
      sda_ch <= {sda_ch[STAGES-2:0], sda_i};
      scl_d  <= scl_ch[STAGES-1];
      sda_d  <= sda_ch[STAGES-1];
    end
  end

  assign scl_s    = scl_ch[STAGES-1];
  assign sda_s    = sda_ch[STAGES-1];
  assign sda_lvl  = sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/sr_regfile.sv
module sr_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 waddr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [ADDR_W-1:0]                 raddr,
  output logic [DATA_W-1:0]                 rdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0]     flat
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wdata;
    end
    assign flat[g*DATA_W +: DATA_W] = mem_q[g];
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/serial_regbank_slave.sv
module serial_regbank_slave #(
  parameter int          ADDR_W      = 7,
  parameter int          DATA_W      = 8,
  parameter logic [6:0]  DEV_ID      = 7'h12,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_clk_i,
  input  logic                          ser_dat_i,
  output logic                          resp_o,
  output logic [(1<<ADDR_W)*DATA_W-1:0] reg_bus_o
);
  import sr_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] RX_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(DATA_W - 1);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  sr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s),
    .scl_i    (ser_clk_i),
    .sda_i    (ser_dat_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  sr_state_e         state_q, state_d;
  sr_kind_e          kind_q, kind_d;
  logic              rd_mode_q, rd_mode_d;
  logic              mack_q, mack_d;
  logic              resp_q, resp_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [DATA_W-1:0] shr_q, shr_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              we;
  logic [DATA_W-1:0] rdata;

  sr_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_s),
    .we    (we),
    .waddr (ptr_q),
    .wdata (shr_q),
    .raddr (ptr_q),
    .rdata (rdata),
    .flat  (reg_bus_o)
  );

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    rd_mode_d = rd_mode_q;
    mack_d    = mack_q;
    resp_d    = resp_q;
    bcnt_d    = bcnt_q;
    shr_d     = shr_q;
    ptr_d     = ptr_q;
    we        = 1'b0;
    if (stop_ev) begin
      state_d = ST_IDLE;
      resp_d  = 1'b0;
    end else if (start_ev) begin
      state_d   = ST_RX;
      kind_d    = K_DEV;
      rd_mode_d = 1'b0;
      bcnt_d    = '0;
      resp_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shr_d  = {shr_q[DATA_W-2:0], sda_lvl};
            bcnt_d = bcnt_q + 1'b1;
          end else if (scl_fall && bcnt_q == RX_FULL) begin
            bcnt_d = '0;
            unique case (kind_q)
              K_DEV: begin
                if (shr_q[DATA_W-1:1] == DEV_ID) begin
                  resp_d    = 1'b1;
                  rd_mode_d = shr_q[0];
                  kind_d    = K_PTR;
                  state_d   = ST_RACK;
                end else begin
                  state_d = ST_SKIP;
                end
              end
              K_PTR: begin
                ptr_d   = shr_q[ADDR_W-1:0];
                kind_d  = K_DATA;
                resp_d  = 1'b1;
                state_d = ST_RACK;
              end
              default: begin
                we      = 1'b1;
                ptr_d   = ptr_q + 1'b1;
                resp_d  = 1'b1;
                state_d = ST_RACK;
              end
            endcase
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            bcnt_d = '0;
            if (rd_mode_q) begin
              shr_d   = rdata;
              ptr_d   = ptr_q + 1'b1;
              resp_d  = ~rdata[DATA_W-1];
              state_d = ST_TX;
            end else begin
              resp_d  = 1'b0;
              state_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bcnt_q == TX_LAST) begin
              resp_d  = 1'b0;
              state_d = ST_MACK;
            end else begin
              shr_d  = {shr_q[DATA_W-2:0], 1'b0};
              resp_d = ~shr_q[DATA_W-2];
              bcnt_d = bcnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              shr_d   = rdata;
              ptr_d   = ptr_q + 1'b1;
              resp_d  = ~rdata[DATA_W-1];
              bcnt_d  = '0;
              state_d = ST_TX;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_DEV;
      rd_mode_q <= 1'b0;
      mack_q    <= 1'b0;
      resp_q    <= 1'b0;
      bcnt_q    <= '0;
      shr_q     <= '0;
      ptr_q     <= '0;
    end else begin
      state_q   <= state_d;
      kind_q    <= kind_d;
      rd_mode_q <= rd_mode_d;
      mack_q    <= mack_d;
      resp_q    <= resp_d;
      bcnt_q    <= bcnt_d;
      shr_q     <= shr_d;
      ptr_q     <= ptr_d;
    end
  end

  assign resp_o = resp_q;
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall,
  input logic              stop_ev,
  input logic              resp_o,
  input logic              we,
  input logic              rd_mode,
  input logic [ADDR_W-1:0] ptr,
  input sr_pkg::sr_state_e state
);
  import sr_pkg::*;

  assert_quiet_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !resp_o);

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !resp_o);

  assert_rise_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_o) |-> $past(scl_fall));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  assert_no_write_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !rd_mode);

  assert_skip_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !resp_o);
endmodule

bind serial_regbank_slave sr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_fall (scl_fall),
  .stop_ev  (stop_ev),
  .resp_o   (resp_o),
  .we       (we),
  .rd_mode  (rd_mode_q),
  .ptr      (ptr_q),
  .state    (state_q)
);

// File: tb/tb_serial_regbank_slave.sv
`timescale 1ns/1ps
module tb_serial_regbank_slave;
  localparam int Q = 6;
  localparam int NV = 6;
  // entry: {register address, data}
  localparam logic [15:0] VEC [NV] = '{16'h00A5, 16'h015A, 16'h3C81,
                                      16'h40FF, 16'h7F3E, 16'h2B00};

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda;
  logic resp;
  logic [1023:0] bus;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_regbank_slave dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk_i (scl),
    .ser_dat_i (sda),
    .resp_o    (resp),
    .reg_bus_o (bus)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] reg_at(input int a);
    return bus[a*8 +: 8];
  endfunction

  task automatic bus_start();
    sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda = b[i]; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0;
    end
    sda = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    acked = resp;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = ~resp;
      tick(Q);
      scl = 1'b0;
    end
    tick(Q);
    sda = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
    sda = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] a);
    bit ak;
    bus_start();
    send_byte(8'h24, ak); chk(ak, "R3 write device ack", 32'(ak), 1);
    send_byte(a, ak);     chk(ak, "R4 pointer byte ack", 32'(ak), 1);
    bus_stop();
  endtask

  initial begin
    bit ak;
    logic [7:0] rb;
    logic [1023:0] snap;
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
    tick(5);
    chk(resp == 1'b0, "R1 resp after reset", 32'(resp), 0);
    chk(bus == '0, "R1 registers after reset", 32'(bus[31:0]), 0);
    rst_n = 1'b1;
    tick(10);

    // table walk: write one byte, check bus, read back inverted stream
    for (int v = 0; v < NV; v++) begin
      bus_start();
      send_byte(8'h24, ak);       chk(ak, "R3 device ack", 32'(ak), 1);
      send_byte(VEC[v][15:8], ak); chk(ak, "R4 pointer ack", 32'(ak), 1);
      send_byte(VEC[v][7:0], ak);  chk(ak, "R3 data ack", 32'(ak), 1);
      bus_stop();
      chk(reg_at(VEC[v][15:8]) == VEC[v][7:0], "R4 stored byte",
          32'(reg_at(VEC[v][15:8])), 32'(VEC[v][7:0]));
      set_ptr(VEC[v][15:8]);
      bus_start();
      send_byte(8'h25, ak); chk(ak, "R3 read device ack", 32'(ak), 1);
      recv_byte(1'b0, rb);
      bus_stop();
      chk(rb == VEC[v][7:0], "R6 read byte", 32'(rb), 32'(VEC[v][7:0]));
    end

    // burst write across the wrap point
    bus_start();
    send_byte(8'h24, ak);
    send_byte(8'h7E, ak);
    send_byte(8'h11, ak);
    send_byte(8'h22, ak);
    send_byte(8'h33, ak); chk(ak, "R4 burst ack", 32'(ak), 1);
    bus_stop();
    chk(reg_at(8'h7E) == 8'h11, "R4 burst first", 32'(reg_at(8'h7E)), 32'h11);
    chk(reg_at(8'h7F) == 8'h22, "R5 burst at 7F", 32'(reg_at(8'h7F)), 32'h22);
    chk(reg_at(8'h00) == 8'h33, "R5 wrap to 00", 32'(reg_at(8'h00)), 32'h33);

    // burst read across the wrap point, then host not-acknowledge
    set_ptr(8'h7E);
    bus_start();
    send_byte(8'h25, ak);
    recv_byte(1'b1, rb); chk(rb == 8'h11, "R7 read 7E", 32'(rb), 32'h11);
    recv_byte(1'b1, rb); chk(rb == 8'h22, "R7 read 7F", 32'(rb), 32'h22);
    recv_byte(1'b0, rb); chk(rb == 8'h33, "R5 read wraps", 32'(rb), 32'h33);
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 12; k++) begin
        tick(Q); scl = 1'b1; tick(Q);
        if (resp) seen = 1'b1;
        tick(Q); scl = 1'b0;
        if (resp) seen = 1'b1;
      end
      chk(!seen, "R8 silent after no-ack", 32'(seen), 0);
    end
    bus_stop();
    chk(resp == 1'b0, "R2 resp low after stop", 32'(resp), 0);

    // foreign device address ignored
    snap = bus;
    bus_start();
    send_byte(8'h30, ak); chk(!ak, "R9 no ack on mismatch", 32'(ak), 0);
    send_byte(8'h05, ak); chk(!ak, "R9 no ack after mismatch", 32'(ak), 0);
    send_byte(8'h77, ak);
    bus_stop();
    chk(bus == snap, "R9 registers unchanged", 32'(bus[31:0]), 32'(snap[31:0]));

    // transfer stopped after pointer byte stores nothing
    snap = bus;
    bus_start();
    send_byte(8'h24, ak);
    send_byte(8'h20, ak);
    bus_stop();
    chk(resp == 1'b0, "R2 resp idle after stop", 32'(resp), 0);
    chk(bus == snap, "R2 stop leaves registers", 32'(bus[31:0]), 32'(snap[31:0]));

    // repeated start without stop
    bus_start();
    send_byte(8'h24, ak);
    send_byte(8'h3C, ak);
    bus_start();
    send_byte(8'h25, ak); chk(ak, "R10 ack after repeated start", 32'(ak), 1);
    recv_byte(1'b0, rb);
    bus_stop();
    chk(rb == 8'h81, "R10 read after repeated start", 32'(rb), 32'h81);

    // reset in the middle of operation
    rst_n = 1'b0;
    tick(3);
    chk(bus == '0, "R1 registers cleared", 32'(bus[63:32]), 0);
    chk(resp == 1'b0, "R1 resp cleared", 32'(resp), 0);
    rst_n = 1'b1;
    tick(5);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule